// File: doc/BRIEF.md
# Cluster Power State Controller

This block chooses the power state of the shared domain that holds a cluster of processor cores and their common L2 array. Each clock it looks at every core's present power state, whether the L2 is idle in wait-for-interrupt, and the settings that software has programmed. Those settings are a target state, a logic-retention choice, an L2-retention choice and a clock-transition mode. From these it resolves one domain state (ON, INACT or CSWRET), the state of the L2 array, an enable for the cluster PLL clock and a logic-powered indication.

The domain is never allowed to sit below its most active core, and it never steps straight from one low-power state to another. A wakeup event, a core coming back ON or the L2 leaving idle brings the domain back to ON. The PLL clock enable rises in the same cycle as that cause, one edge before the domain reports ON. Programming that fits no legal combination raises an illegal flag. While the flag is set the domain keeps its present state, unless a wakeup cause forces ON.

Top module: `cluster_pwr_ctrl`

## Requirements
- R1: While rst_n is low, and after it is released, the outputs are: dom_st ON (2'b11), l2_st ON (2'b11), dpll_en 1, logic_on 1 and illegal 0.
- R2: Power-state codes for cores, target and domain are 2'b11 ON, 2'b01 INACT and 2'b00 CSWRET/RETENTION; 2'b10 is invalid. If any core reports ON, then after the next edge dom_st and l2_st are ON and dpll_en is 1.
- R3: If l2_idle is 0, then after the next edge dom_st and l2_st are ON.
- R4: Clock-mode codes are 2'b00 NO_SLEEP, 2'b10 SW_WKUP and 2'b11 HW_AUTO; 2'b01 is invalid. With no core ON and l2_idle set, the domain stays ON under NO_SLEEP or SW_WKUP, and under HW_AUTO with target ON.
- R5: From ON, with no core ON, l2_idle set, HW_AUTO and target INACT, the domain enters INACT (2'b01) at the next edge. In INACT, l2_st is ON, logic_on is 1 and dpll_en is 0 while no wakeup cause is present.
- R6: From ON, with every core at CSWRET, l2_idle set, HW_AUTO, target RETENTION and logic_ret 1, the domain enters CSWRET (2'b00). Inside CSWRET, l2_st is RET (2'b01) if l2_ret was 1 at entry and OFF (2'b00) if it was 0; later changes to l2_ret are ignored until the domain leaves. dpll_en is 0 in CSWRET.
- R7: While in INACT or CSWRET, a legal request for the other low-power state leaves dom_st unchanged. A request that resolves to ON (target ON, or a mode other than HW_AUTO) returns the domain to ON at the next edge.
- R8: While the domain is low-power, a wakeup cause (wakeup 1, a core ON, or l2_idle 0) drives dpll_en to 1 in that same cycle, and dom_st is ON after the next edge.
- R9: illegal is set one edge after any of these: an invalid code on a core, the target or the mode; target RETENTION while a core is ON; or, with no core ON, l2_idle set and HW_AUTO, target RETENTION without every core at CSWRET and logic_ret 1. While illegal programming is present and no wakeup cause exists, dom_st holds.
- R10: illegal clears at the first edge at which the inputs form a legal combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| core_st | input | 2*NUM_CORES | Per-core power state, core i at bits [2i+1:2i] |
| l2_idle | input | 1 | Shared L2 is idle in wait-for-interrupt |
| tgt_st | input | 2 | Programmed target domain state |
| logic_ret | input | 1 | 1 selects CSWRET logic retention |
| l2_ret | input | 1 | 1 keeps L2 in retention in CSWRET, 0 powers it off |
| clk_mode | input | 2 | Clock-transition mode |
| wakeup | input | 1 | Wakeup event |
| dom_st | output | 2 | Resolved domain power state |
| l2_st | output | 2 | L2 array state: 11 ON, 01 RET, 00 OFF |
| dpll_en | output | 1 | Cluster PLL clock enable |
| logic_on | output | 1 | Cluster logic powered |
| illegal | output | 1 | Programmed inputs match no legal combination |

## Verification
The bench builds the controller with the default NUM_CORES of 2. With two cores, the mixed-core cases can be reached: one core ON while the other is at CSWRET, one core at INACT with the other at CSWRET (which blocks the retention entry), and a single invalid code on either core. The random mix is biased toward low core states, HW_AUTO and a RETENTION target, so that CSWRET entries with both L2 choices, the blocked transitions between low-power states, and wakeups from each low state occur many times.

// File: rtl/cpsc_pkg.sv
package cpsc_pkg;
  typedef enum logic [1:0] {
    PS_LOW   = 2'b00,
    PS_INACT = 2'b01,
    PS_BAD   = 2'b10,
    PS_ON    = 2'b11
  } pwr_e;

  typedef enum logic [1:0] {
    CM_NOSLEEP = 2'b00,
    CM_BAD     = 2'b01,
    CM_SWWK    = 2'b10,
    CM_HWAUTO  = 2'b11
  } clkm_e;

  localparam logic [1:0] L2_OFF = 2'b00;
  localparam logic [1:0] L2_RET = 2'b01;
  localparam logic [1:0] L2_ON  = 2'b11;
endpackage

// File: rtl/cpsc_core_agg.sv
module cpsc_core_agg
  import cpsc_pkg::*;
#(
  parameter int NUM_CORES = 2
) (
  input  logic [2*NUM_CORES-1:0] core_st,
  output logic                   any_on,
  output logic                   all_low,
  output logic                   any_bad
);
  logic [NUM_CORES-1:0] is_on, is_low, is_bad;

  for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_core
    logic [1:0] code;
    assign code      = core_st[2*gi +: 2];
    assign is_on[gi]  = (code == PS_ON);
    assign is_low[gi] = (code == PS_LOW);
    assign is_bad[gi] = (code == PS_BAD);
  end

  assign any_on  = |is_on;
  assign all_low = &is_low;
  assign any_bad = |is_bad;
endmodule

// File: rtl/cpsc_resolve.sv
module cpsc_resolve
  import cpsc_pkg::*;
(
  input  logic  any_on,
  input  logic  all_low,
  input  logic  any_bad,
  input  logic  l2_idle,
  input  pwr_e  tgt,
  input  logic  logic_ret,
  input  clkm_e mode,
  input  logic  wakeup,
  output logic  force_on,
  output pwr_e  req,
  output logic  illegal
);
  logic quiet;

  always_comb begin
    quiet    = ~any_on & l2_idle;
    force_on = wakeup | any_on | ~l2_idle;

    illegal = any_bad | (tgt == PS_BAD) | (mode == CM_BAD)
            | ((tgt == PS_LOW) & any_on)
            | (quiet & (mode == CM_HWAUTO) & (tgt == PS_LOW) & ~(all_low & logic_ret));

    req = PS_ON;
    if (mode == CM_HWAUTO) begin
      unique case (tgt)
        PS_INACT: req = PS_INACT;
        PS_LOW:   req = PS_LOW;
        default:  req = PS_ON;
      endcase
    end
  end
endmodule

// File: rtl/cluster_pwr_ctrl.sv
// rst_n is expected to assert asynchronously and deassert in step with clk.
module cluster_pwr_ctrl
  import cpsc_pkg::*;
#(
  parameter int NUM_CORES = 2,
  localparam int CW = 2 * NUM_CORES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] core_st,
  input  logic          l2_idle,
  input  logic [1:0]    tgt_st,
  input  logic          logic_ret,
  input  logic          l2_ret,
  input  logic [1:0]    clk_mode,
  input  logic          wakeup,
  output logic [1:0]    dom_st,
  output logic [1:0]    l2_st,
  output logic          dpll_en,
  output logic          logic_on,
  output logic          illegal
);
  logic any_on, all_low, any_bad;
  logic force_on, ill_now;
  pwr_e req;

  pwr_e dom_q, dom_d;
  logic keep_q, keep_en;
  logic ill_q;

  cpsc_core_agg #(.NUM_CORES(NUM_CORES)) agg_i (
    .core_st (core_st),
    .any_on  (any_on),
    .all_low (all_low),
    .any_bad (any_bad)
  );

  cpsc_resolve res_i (
    .any_on    (any_on),
    .all_low   (all_low),
    .any_bad   (any_bad),
    .l2_idle   (l2_idle),
    .tgt       (pwr_e'(tgt_st)),
    .logic_ret (logic_ret),
    .mode      (clkm_e'(clk_mode)),
    .wakeup    (wakeup),
    .force_on  (force_on),
    .req       (req),
    .illegal   (ill_now)
  );

  // Next state: wake causes win, illegal programming holds, and a low
  // state may only be left toward ON.
  always_comb begin
    dom_d = dom_q;
    if (force_on) begin
      dom_d = PS_ON;
    end else if (!ill_now) begin
      if ((dom_q == PS_ON) || (req == PS_ON)) dom_d = req;
    end
    keep_en = (dom_d == PS_LOW) && (dom_q != PS_LOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_q <= PS_ON;
      keep_q <= 1'b1;
      ill_q <= 1'b0;
    end else begin
      dom_q <= dom_d;
      ill_q <= ill_now;
      if (keep_en) keep_q <= l2_ret;
    end
  end

  assign dom_st   = dom_q;
  assign l2_st    = (dom_q == PS_LOW) ? (keep_q ? L2_RET : L2_OFF) : L2_ON;
  assign dpll_en  = (dom_q == PS_ON) | force_on;
  assign logic_on = (dom_q != PS_BAD);
  assign illegal  = ill_q;
endmodule

// File: rtl/cluster_pwr_ctrl_chk.sv
module cluster_pwr_ctrl_chk #(
  parameter int NUM_CORES = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [2*NUM_CORES-1:0] core_st,
  input logic                   l2_idle,
  input logic [1:0]             clk_mode,
  input logic                   wakeup,
  input logic [1:0]             dom_st,
  input logic [1:0]             l2_st,
  input logic                   dpll_en,
  input logic                   logic_on,
  input logic                   illegal
);
  logic some_on;
  always_comb begin
    some_on = 1'b0;
    for (int i = 0; i < NUM_CORES; i++)
      if (core_st[2*i +: 2] == 2'b11) some_on = 1'b1;
  end

  p_core_lifts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    some_on |=> (dom_st == 2'b11) && (l2_st == 2'b11));

  p_l2_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !l2_idle |=> (dom_st == 2'b11));

  p_inact_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_st == 2'b01) |-> (l2_st == 2'b11) && logic_on);

  p_inact_no_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_st == 2'b01) |=> (dom_st != 2'b00));

  p_ret_no_inact_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_st == 2'b00) |=> (dom_st != 2'b01));

  p_wake_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wakeup |-> dpll_en);

  p_wake_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wakeup |=> (dom_st == 2'b11));

  p_bad_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_mode == 2'b01) && !wakeup && !some_on && l2_idle)
      |=> illegal && $stable(dom_st));
endmodule

bind cluster_pwr_ctrl cluster_pwr_ctrl_chk #(.NUM_CORES(NUM_CORES)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .core_st  (core_st),
  .l2_idle  (l2_idle),
  .clk_mode (clk_mode),
  .wakeup   (wakeup),
  .dom_st   (dom_st),
  .l2_st    (l2_st),
  .dpll_en  (dpll_en),
  .logic_on (logic_on),
  .illegal  (illegal)
);

// File: tb/cluster_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module cluster_pwr_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] c0 = 2'b11, c1 = 2'b11, tgt = 2'b11, mode = 2'b00;
  logic idle = 1'b1, lret = 1'b1, l2r = 1'b1, wk = 1'b0;

  logic [1:0] dom_st, l2_st;
  logic dpll_en, logic_on, illegal;

  cluster_pwr_ctrl #(.NUM_CORES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .core_st({c1, c0}), .l2_idle(idle),
    .tgt_st(tgt), .logic_ret(lret), .l2_ret(l2r), .clk_mode(mode),
    .wakeup(wk), .dom_st(dom_st), .l2_st(l2_st), .dpll_en(dpll_en),
    .logic_on(logic_on), .illegal(illegal)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [1:0] m_dom = 2'b11;
  logic m_keep = 1'b1, m_ill = 1'b0;

  task automatic chk(string req, string what, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Bench model of the requirements.
  task automatic step(input logic [1:0] a0, a1, at, am,
                      input logic ai, alr, al2, aw);
    logic any_on, all_low, bcode, frc, ill;
    logic [1:0] rq, nx;
    string tag;
    @(negedge clk);
    c0 = a0; c1 = a1; tgt = at; mode = am; idle = ai; lret = alr; l2r = al2; wk = aw;
    any_on  = (c0 == 2'b11) || (c1 == 2'b11);
    all_low = (c0 == 2'b00) && (c1 == 2'b00);
    bcode   = (c0 == 2'b10) || (c1 == 2'b10);
    frc     = wk || any_on || !idle;
    ill = bcode || (tgt == 2'b10) || (mode == 2'b01) || (tgt == 2'b00 && any_on)
       || (!any_on && idle && mode == 2'b11 && tgt == 2'b00 && !(all_low && lret));
    rq = (mode != 2'b11) ? 2'b11 : (tgt == 2'b01) ? 2'b01 : (tgt == 2'b00) ? 2'b00 : 2'b11;
    if (frc) nx = 2'b11;
    else if (ill) nx = m_dom;
    else if (m_dom == 2'b11 || rq == 2'b11) nx = rq;
    else nx = m_dom;
    if (any_on) tag = "R2";
    else if (!idle) tag = "R3";
    else if (wk) tag = "R8";
    else if (ill) tag = "R9";
    else if (m_dom != 2'b11) tag = "R7";
    else if (nx == 2'b01) tag = "R5";
    else if (nx == 2'b00) tag = "R6";
    else tag = "R4";
    #1;
    chk((m_dom != 2'b11 && frc) ? "R8" : "R5", "dpll_en", {1'b0, dpll_en},
        {1'b0, (m_dom == 2'b11) || frc});
    @(posedge clk);
    if (nx == 2'b00 && m_dom != 2'b00) m_keep = l2r;
    m_dom = nx;
    m_ill = ill;
    #1;
    chk(tag, "dom_st", dom_st, m_dom);
    chk("R6", "l2_st", l2_st, (m_dom == 2'b00) ? (m_keep ? 2'b01 : 2'b00) : 2'b11);
    chk(m_ill ? "R9" : "R10", "illegal", {1'b0, illegal}, {1'b0, m_ill});
    chk("R5", "logic_on", {1'b0, logic_on}, 2'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd9137));
    repeat (3) @(posedge clk);
    #1;
    // R1: state held in reset
    chk("R1", "dom_st", dom_st, 2'b11);
    chk("R1", "l2_st", l2_st, 2'b11);
    chk("R1", "dpll_en/illegal", {dpll_en, illegal}, 2'b10);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "dom_st after release", dom_st, 2'b11);

    // R4: cores idle but NO_SLEEP, SW_WKUP, or HW_AUTO with target ON
    step(2'b01, 2'b00, 2'b01, 2'b00, 1, 1, 1, 0);
    step(2'b01, 2'b00, 2'b00, 2'b10, 1, 1, 1, 0);
    step(2'b01, 2'b00, 2'b11, 2'b11, 1, 1, 1, 0);
    // R5: enter INACT, then R7: retention request is blocked
    step(2'b01, 2'b00, 2'b01, 2'b11, 1, 1, 1, 0);
    step(2'b00, 2'b00, 2'b00, 2'b11, 1, 1, 1, 0);
    step(2'b00, 2'b00, 2'b00, 2'b11, 1, 1, 1, 0);
    // R8: wakeup from INACT
    step(2'b00, 2'b00, 2'b00, 2'b11, 1, 1, 1, 1);
    // R6: retention entry with L2 kept, later l2_ret change ignored
    step(2'b00, 2'b00, 2'b00, 2'b11, 1, 1, 1, 0);
    step(2'b00, 2'b00, 2'b00, 2'b11, 1, 1, 0, 0);
    // R7: INACT request from CSWRET is blocked
    step(2'b00, 2'b00, 2'b01, 2'b11, 1, 1, 0, 0);
    // R2: a core back ON wakes the domain
    step(2'b11, 2'b00, 2'b01, 2'b11, 1, 1, 0, 0);
    // R6: entry with L2 off
    step(2'b00, 2'b00, 2'b00, 2'b11, 1, 1, 0, 0);
    // R3: L2 busy wakes
    step(2'b00, 2'b00, 2'b00, 2'b11, 0, 1, 0, 0);
    // R9: retention with a core ON, invalid mode, missing logic retention
    step(2'b11, 2'b00, 2'b00, 2'b11, 1, 1, 1, 0);
    step(2'b01, 2'b00, 2'b01, 2'b01, 1, 1, 1, 0);
    step(2'b00, 2'b00, 2'b00, 2'b11, 1, 0, 1, 0);
    step(2'b10, 2'b00, 2'b01, 2'b11, 1, 1, 1, 0);
    // R10: legal again
    step(2'b01, 2'b01, 2'b11, 2'b11, 1, 1, 1, 0);

    for (int n = 0; n < 3000; n++) begin
      logic [1:0] rc [2];
      logic [1:0] rt, rm;
      for (int k = 0; k < 2; k++) begin
        int r = $urandom % 10;
        rc[k] = (r < 2) ? 2'b11 : (r < 4) ? 2'b01 : (r < 9) ? 2'b00 : 2'b10;
      end
      case ($urandom % 8)
        0: rm = 2'b00; 1: rm = 2'b10; 2: rm = 2'b01; default: rm = 2'b11;
      endcase
      case ($urandom % 8)
        0: rt = 2'b11; 1: rt = 2'b10; 2, 3, 4: rt = 2'b01; default: rt = 2'b00;
      endcase
      step(rc[0], rc[1], rt, rm, ($urandom % 8) != 0, ($urandom % 4) != 0,
           $urandom % 2, ($urandom % 16) == 0);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule